// File: doc/BRIEF.md
# Indexed Effective-Address Unit

This unit turns one indexed-addressing postbyte of an 8-bit processor into a 16-bit effective address. A start pulse captures the postbyte and a snapshot of the four pointer registers (X, Y, U, S), the two accumulators and the program counter. The postbyte then picks one of several ways to form the address. It can add a short constant from the postbyte itself. It can use the pointer as it is, or add an accumulator or the combined 16-bit accumulator pair. It can add a constant of one or two bytes taken from the instruction stream, or add such a constant to the program counter. It can step the pointer up or down. It can also take an absolute address from the stream.

Offset bytes are pulled from the instruction stream only when the chosen form needs them. Each accepted byte advances the program-counter output. When the indirect bit is set, the unit fetches a 16-bit word through a byte-wide read port at the computed address, and that word becomes the result. Auto-step forms report the new pointer value on a write-back strobe, so the register file can update the register. A one-cycle done pulse marks the result. Illegal forms also raise a flag.

Top module: `idx_ea_unit`

## Requirements
- R1: Postbyte bits 6:5 choose the base pointer: 0 selects X, 1 selects Y, 2 selects U and 3 selects S.
- R2: With postbyte bit 7 clear, bits 4:0 are a signed 5-bit constant that is sign-extended and added to the base. No stream byte is fetched and no indirect read is made.
- R3: With bit 7 set, mode field bits 3:0 values 0 and 1 give the old base as the address and write back base+1 or base+2. Values 2 and 3 write back base-1 or base-2 and give that new value as the address. wb_en is high only in the done cycle, and wb_sel equals bits 6:5.
- R4: With bit 7 set, mode 4 gives the base unchanged. Mode 5 adds sign-extended B, mode 6 adds sign-extended A, and mode 11 adds the 16-bit value with A as the high byte and B as the low byte.
- R5: Mode 8 fetches one stream byte and adds it to the base as a signed value. Mode 9 fetches two stream bytes, the first as the high byte, and adds the 16-bit value to the base.
- R6: Mode 12 fetches one signed byte and mode 13 fetches a 16-bit value. Both add it to the program counter as it stands after those bytes have been fetched.
- R7: Mode 15 fetches two stream bytes, high byte first, and uses them directly as the address.
- R8: Modes 7, 10 and 14 are illegal. They finish with address 0 and bad_mode high in the done cycle, with no stream fetch, no indirect read and no write-back.
- R9: When bit 7 and bit 4 are both set on a legal mode, the unit reads the byte at the computed address and then the byte at the computed address plus 1. The final address is the first byte as the high half and the second byte as the low half. While a read waits for rd_ack, rd_req and rd_addr hold.
- R10: All address sums wrap modulo 65536, and the second byte of an indirect read at 0xFFFF comes from 0x0000.
- R11: A stream byte is taken on each clock edge where ob_req and ob_ack are both high, and ob_req stays high until one is taken. pc_out loads pc_in at start and rises by exactly 1 for each taken byte.
- R12: After reset, done, ob_req, rd_req and wb_en are low and pc_out is 0. done lasts one cycle, and a start while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| pbyte | input | 8 | Indexed postbyte |
| ptr_x | input | 16 | X pointer |
| ptr_y | input | 16 | Y pointer |
| ptr_u | input | 16 | U pointer |
| ptr_s | input | 16 | S pointer |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| pc_in | input | 16 | Program counter just past the postbyte |
| ob_req | output | 1 | Requesting a stream byte |
| ob_ack | input | 1 | Stream byte offered this cycle |
| ob_data | input | 8 | Stream byte |
| pc_out | output | 16 | Program counter after consumed bytes |
| rd_req | output | 1 | Indirect byte read request |
| rd_addr | output | 16 | Indirect read address |
| rd_ack | input | 1 | Indirect read data valid |
| rd_data | input | 8 | Indirect read data |
| done | output | 1 | Effective address valid (one cycle) |
| ea | output | 16 | Effective address |
| bad_mode | output | 1 | Illegal mode, with done |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer to update (0 X, 1 Y, 2 U, 3 S) |
| wb_val | output | 16 | New pointer value |

## Verification
The pointer write-back and the final address both land in the done cycle. The hardest case is an auto-increment form that is also indirect, where the strobe must wait until both pointer-word reads have finished. The bench provokes this with a post-increment-by-2 indirect postbyte while it stalls the read port on alternate cycles. In the single cycle where done is high, it checks that wb_en, wb_sel and wb_val match the step, and that ea holds the fetched word rather than the pointer. The same stalled handshake on the stream port checks that pc_out has advanced by the number of bytes consumed, and no more, when done arrives.

// File: rtl/idx_ea_unit.sv
module idx_ea_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  pbyte,
  input  logic [15:0] ptr_x,
  input  logic [15:0] ptr_y,
  input  logic [15:0] ptr_u,
  input  logic [15:0] ptr_s,
  input  logic [7:0]  acc_a,
  input  logic [7:0]  acc_b,
  input  logic [15:0] pc_in,
  output logic        ob_req,
  input  logic        ob_ack,
  input  logic [7:0]  ob_data,
  output logic [15:0] pc_out,
  output logic        rd_req,
  output logic [15:0] rd_addr,
  input  logic        rd_ack,
  input  logic [7:0]  rd_data,
  output logic        done,
  output logic [15:0] ea,
  output logic        bad_mode,
  output logic        wb_en,
  output logic [1:0]  wb_sel,
  output logic [15:0] wb_val
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CALC, S_IND, S_FIN} st_t;

  st_t         st;
  logic [7:0]  pb_q, a_q, b_q, hi_q;
  logic [15:0] base_q, pc_q, ofs_q, ea_q;
  logic [1:0]  left_q;
  logic        rd_ph;
  logic [15:0] calc;

  function automatic logic [1:0] ofs_len(input logic [7:0] p);
    if (!p[7]) return 2'd0;
    case (p[3:0])
      4'd8, 4'd12:         return 2'd1;
      4'd9, 4'd13, 4'd15:  return 2'd2;
      default:             return 2'd0;
    endcase
  endfunction

  wire [3:0]  md      = pb_q[3:0];
  wire        lng     = pb_q[7];
  wire        illegal = lng && (md == 4'd7 || md == 4'd10 || md == 4'd14);
  wire        indir   = lng && pb_q[4] && !illegal;
  wire        autostp = lng && (md[3:2] == 2'b00);
  wire [15:0] s8      = {{8{ofs_q[7]}}, ofs_q[7:0]};
  wire [1:0]  len_in  = ofs_len(pbyte);

  always_comb begin
    if (!lng) calc = base_q + {{11{pb_q[4]}}, pb_q[4:0]};
    else begin
      case (md)
        4'd0, 4'd1, 4'd4: calc = base_q;
        4'd2:  calc = base_q - 16'd1;
        4'd3:  calc = base_q - 16'd2;
        4'd5:  calc = base_q + {{8{b_q[7]}}, b_q};
        4'd6:  calc = base_q + {{8{a_q[7]}}, a_q};
        4'd8:  calc = base_q + s8;
        4'd9:  calc = base_q + ofs_q;
        4'd11: calc = base_q + {a_q, b_q};
        4'd12: calc = pc_q + s8;
        4'd13: calc = pc_q + ofs_q;
        4'd15: calc = ofs_q;
        default: calc = 16'd0;
      endcase
    end
  end

  always_comb begin
    case (md[1:0])
      2'd0: wb_val = base_q + 16'd1;
      2'd1: wb_val = base_q + 16'd2;
      2'd2: wb_val = base_q - 16'd1;
      default: wb_val = base_q - 16'd2;
    endcase
  end

  assign ob_req   = (st == S_FETCH);
  assign rd_req   = (st == S_IND);
  assign rd_addr  = ea_q + {15'd0, rd_ph};
  assign done     = (st == S_FIN);
  assign ea       = ea_q;
  assign bad_mode = done && illegal;
  assign wb_en    = done && autostp;
  assign wb_sel   = pb_q[6:5];
  assign pc_out   = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pb_q   <= 8'd0;
      a_q    <= 8'd0;
      b_q    <= 8'd0;
      hi_q   <= 8'd0;
      base_q <= 16'd0;
      pc_q   <= 16'd0;
      ofs_q  <= 16'd0;
      ea_q   <= 16'd0;
      left_q <= 2'd0;
      rd_ph  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          pb_q   <= pbyte;
          a_q    <= acc_a;
          b_q    <= acc_b;
          pc_q   <= pc_in;
          ofs_q  <= 16'd0;
          left_q <= len_in;
          case (pbyte[6:5])
            2'd0: base_q <= ptr_x;
            2'd1: base_q <= ptr_y;
            2'd2: base_q <= ptr_u;
            default: base_q <= ptr_s;
          endcase
          st <= (len_in != 2'd0) ? S_FETCH : S_CALC;
        end
        S_FETCH: if (ob_ack) begin
          ofs_q  <= {ofs_q[7:0], ob_data};
          pc_q   <= pc_q + 16'd1;
          left_q <= left_q - 2'd1;
          if (left_q == 2'd1) st <= S_CALC;
        end
        S_CALC: begin
          ea_q  <= calc;
          rd_ph <= 1'b0;
          st    <= indir ? S_IND : S_FIN;
        end
        S_IND: if (rd_ack) begin
          if (!rd_ph) begin
            hi_q  <= rd_data;
            rd_ph <= 1'b1;
          end else begin
            ea_q <= {hi_q, rd_data};
            st   <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ob_req,
  input logic        ob_ack,
  input logic [15:0] pc_out,
  input logic        rd_req,
  input logic [15:0] rd_addr,
  input logic        rd_ack,
  input logic        done,
  input logic        bad_mode,
  input logic        wb_en
);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R3
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) wb_en |-> done);

  // R8
  bad_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n) bad_mode |-> (done && !wb_en));

  // R11
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_req && ob_ack) |=> (pc_out == $past(pc_out) + 16'd1));

  // R11
  ob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (ob_req && !ob_ack) |=> ob_req);

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R9
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ob_req && rd_req));

  // R11
  pc_quiet_rd_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |=> $stable(pc_out));

  // R5
  fetch_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n) ob_req |-> !done);

endmodule

bind idx_ea_unit idx_ea_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ob_req(ob_req), .ob_ack(ob_ack), .pc_out(pc_out),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .done(done),
  .bad_mode(bad_mode), .wb_en(wb_en)
);

// File: tb/idx_ea_unit_test.sv
module idx_ea_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] pbyte = 8'd0, acc_a = 8'd0, acc_b = 8'd0, ob_data = 8'd0, rd_data = 8'd0;
  logic [15:0] ptr_x = 16'd0, ptr_y = 16'd0, ptr_u = 16'd0, ptr_s = 16'd0, pc_in = 16'd0;
  logic ob_ack = 1'b0, rd_ack = 1'b0;
  logic ob_req, rd_req, done, bad_mode, wb_en;
  logic [15:0] pc_out, rd_addr, ea, wb_val;
  logic [1:0] wb_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  idx_ea_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pbyte(pbyte),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_u(ptr_u), .ptr_s(ptr_s),
    .acc_a(acc_a), .acc_b(acc_b), .pc_in(pc_in),
    .ob_req(ob_req), .ob_ack(ob_ack), .ob_data(ob_data), .pc_out(pc_out),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .done(done), .ea(ea), .bad_mode(bad_mode), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic run_op(input string rq, input logic [7:0] pb,
                        input logic [15:0] x, input logic [15:0] y,
                        input logic [15:0] u, input logic [15:0] s,
                        input logic [7:0] a, input logic [7:0] b, input logic [15:0] pc,
                        input logic [7:0] s0, input logic [7:0] s1,
                        input bit stall, input bit poke);
    logic [15:0] base, ofs, e, nv;
    logic [7:0] strm [2];
    logic [15:0] rda [2];
    int nf, nrd, got_f;
    bit ill, ind, aut, seen;
    logic [15:0] c_ea, c_pc, c_wv;
    logic c_wb, c_bad;
    logic [1:0] c_ws;
    strm[0] = s0; strm[1] = s1;
    rda[0] = 16'd0; rda[1] = 16'd0;
    case (pb[6:5])
      2'd0: base = x; 2'd1: base = y; 2'd2: base = u; default: base = s;
    endcase
    ill = pb[7] && (pb[3:0] == 4'd7 || pb[3:0] == 4'd10 || pb[3:0] == 4'd14);
    nf = 0;
    if (pb[7] && (pb[3:0] == 4'd8 || pb[3:0] == 4'd12)) nf = 1;
    if (pb[7] && (pb[3:0] == 4'd9 || pb[3:0] == 4'd13 || pb[3:0] == 4'd15)) nf = 2;
    ofs = (nf == 2) ? {s0, s1} : {{8{s0[7]}}, s0};
    aut = pb[7] && pb[3:0] < 4'd4;
    nv = 16'd0;
    if (!pb[7]) e = base + {{11{pb[4]}}, pb[4:0]};
    else begin
      case (pb[3:0])
        4'd0: begin e = base; nv = base + 16'd1; end
        4'd1: begin e = base; nv = base + 16'd2; end
        4'd2: begin nv = base - 16'd1; e = nv; end
        4'd3: begin nv = base - 16'd2; e = nv; end
        4'd4: e = base;
        4'd5: e = base + {{8{b[7]}}, b};
        4'd6: e = base + {{8{a[7]}}, a};
        4'd8, 4'd9: e = base + ofs;
        4'd11: e = base + {a, b};
        4'd12, 4'd13: e = pc + 16'(nf) + ofs;
        4'd15: e = ofs;
        default: e = 16'd0;
      endcase
    end
    ind = pb[7] && pb[4] && !ill;
    @(negedge clk);
    start = 1'b1; pbyte = pb; ptr_x = x; ptr_y = y; ptr_u = u; ptr_s = s;
    acc_a = a; acc_b = b; pc_in = pc;
    @(negedge clk);
    if (poke) pbyte = 8'h87; else start = 1'b0;
    ptr_x = ~x; ptr_y = ~y; ptr_u = ~u; ptr_s = ~s; acc_a = ~a; acc_b = ~b; pc_in = ~pc;
    got_f = 0; nrd = 0; seen = 0;
    c_ea = 0; c_pc = 0; c_wv = 0; c_wb = 0; c_bad = 0; c_ws = 0;
    for (int cyc = 0; cyc < 40 && !seen; cyc++) begin
      ob_ack = 1'b0; rd_ack = 1'b0;
      if (done) begin
        seen = 1; start = 1'b0;
        c_ea = ea; c_pc = pc_out; c_wb = wb_en; c_wv = wb_val; c_ws = wb_sel; c_bad = bad_mode;
      end else begin
        if (ob_req && (!stall || cyc[0])) begin
          ob_ack = 1'b1; ob_data = strm[got_f < 2 ? got_f : 1]; got_f++;
        end
        if (rd_req && (!stall || cyc[0])) begin
          rd_ack = 1'b1; rd_data = memf(rd_addr);
          if (nrd < 2) rda[nrd] = rd_addr;
          nrd++;
        end
        @(negedge clk);
      end
    end
    ob_ack = 1'b0; rd_ack = 1'b0; start = 1'b0;
    chk(seen, rq, "done seen", 32'(seen), 1);
    if (ind) begin
      chk(rda[0] == e, rq, "ptr read addr hi", rda[0], e);
      chk(rda[1] == e + 16'd1, rq, "ptr read addr lo", rda[1], e + 16'd1);
      e = {memf(e), memf(e + 16'd1)};
    end
    chk(nrd == (ind ? 2 : 0), rq, "indirect reads", nrd, ind ? 2 : 0);
    chk(got_f == nf, rq, "stream bytes", got_f, nf);
    chk(c_ea == e, rq, "ea", c_ea, e);
    chk(c_pc == pc + 16'(nf), rq, "pc_out", c_pc, pc + 16'(nf));
    chk(c_wb == aut, rq, "wb_en", c_wb, aut);
    if (aut) begin
      chk(c_wv == nv, rq, "wb_val", c_wv, nv);
      chk(c_ws == pb[6:5], rq, "wb_sel", c_ws, pb[6:5]);
    end
    chk(c_bad == ill, rq, "bad_mode", c_bad, ill);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!done && !ob_req && !rd_req && !wb_en, "R12", "idle outputs",
        {done, ob_req, rd_req, wb_en}, 0);
    chk(pc_out == 16'd0, "R12", "pc_out reset", pc_out, 0);
  endtask

  task automatic t_short;
    run_op("R1", 8'h01, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h00, 8'h00, 16'h0100, 0, 0, 0, 0);
    run_op("R2", 8'h3F, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h00, 8'h00, 16'h0100, 0, 0, 0, 0);
    run_op("R1", 8'h50, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h00, 8'h00, 16'h0100, 0, 0, 0, 0);
    run_op("R2", 8'h6F, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'h00, 8'h00, 16'h0100, 0, 0, 0, 0);
  endtask

  task automatic t_auto;
    run_op("R3", 8'h80, 16'h1234, 16'h2000, 16'h3000, 16'h4000, 8'h00, 8'h00, 16'h0100, 0, 0, 0, 0);
    run_op("R3", 8'hA1, 16'h1234, 16'hFFFF, 16'h3000, 16'h4000, 8'h00, 8'h00, 16'h0100, 0, 0, 0, 0);
    run_op("R3", 8'hC2, 16'h1234, 16'h2000, 16'h3000, 16'h4000, 8'h00, 8'h00, 16'h0100, 0, 0, 0, 0);
    run_op("R10", 8'hE3, 16'h1234, 16'h2000, 16'h3000, 16'h0001, 8'h00, 8'h00, 16'h0100, 0, 0, 0, 0);
  endtask

  task automatic t_acc;
    run_op("R4", 8'h84, 16'h4321, 16'h0, 16'h0, 16'h0, 8'h11, 8'h22, 16'h0100, 0, 0, 0, 0);
    run_op("R4", 8'h85, 16'h4321, 16'h0, 16'h0, 16'h0, 8'h11, 8'h80, 16'h0100, 0, 0, 0, 0);
    run_op("R4", 8'hC6, 16'h0, 16'h0, 16'h5000, 16'h0, 8'h7F, 8'h80, 16'h0100, 0, 0, 0, 0);
    run_op("R4", 8'hAB, 16'h0, 16'h1111, 16'h0, 16'h0, 8'h12, 8'h34, 16'h0100, 0, 0, 0, 0);
  endtask

  task automatic t_ofs;
    run_op("R5", 8'h88, 16'h2000, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0200, 8'h80, 8'h00, 1, 0);
    run_op("R11", 8'hE9, 16'h0, 16'h0, 16'h0, 16'h3000, 8'h0, 8'h0, 16'h0200, 8'h12, 8'h34, 1, 0);
  endtask

  task automatic t_pcrel;
    run_op("R6", 8'h8C, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h1000, 8'hF0, 8'h00, 0, 0);
    run_op("R6", 8'h8D, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'hFFF0, 8'h00, 8'h20, 1, 0);
  endtask

  task automatic t_abs;
    run_op("R7", 8'h8F, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0300, 8'hBE, 8'hEF, 0, 0);
    run_op("R7", 8'h9F, 16'h0, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0300, 8'h55, 8'hAA, 1, 0);
  endtask

  task automatic t_illegal;
    run_op("R8", 8'h87, 16'h1234, 16'h0, 16'h0, 16'h0, 8'h1, 8'h2, 16'h0400, 0, 0, 0, 0);
    run_op("R8", 8'h9A, 16'h1234, 16'h0, 16'h0, 16'h0, 8'h1, 8'h2, 16'h0400, 0, 0, 0, 0);
    run_op("R8", 8'hFE, 16'h0, 16'h0, 16'h0, 16'h7777, 8'h1, 8'h2, 16'h0400, 0, 0, 0, 0);
  endtask

  task automatic t_indirect;
    run_op("R9", 8'h94, 16'h1357, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0500, 0, 0, 0, 0);
    run_op("R9", 8'h91, 16'h2468, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0500, 0, 0, 1, 0);
    run_op("R9", 8'hD8, 16'h0, 16'h0, 16'h6000, 16'h0, 8'h0, 8'h0, 16'h0500, 8'h7F, 8'h0, 1, 0);
  endtask

  task automatic t_wrap;
    run_op("R10", 8'hB4, 16'h0, 16'hFFFF, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0600, 0, 0, 1, 0);
    run_op("R10", 8'h8B, 16'hF000, 16'h0, 16'h0, 16'h0, 8'h20, 8'h01, 16'h0600, 0, 0, 0, 0);
    run_op("R10", 8'h0F, 16'hFFF8, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0600, 0, 0, 0, 0);
  endtask

  task automatic t_busy;
    run_op("R12", 8'h89, 16'h1000, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 16'h0700, 8'h00, 8'h10, 1, 1);
    @(negedge clk);
    chk(!done && !ob_req && !rd_req, "R12", "no restart after done",
        {done, ob_req, rd_req}, 0);
    @(negedge clk);
    chk(!done, "R12", "done stays low", done, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog R12: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_short();
    t_auto();
    t_acc();
    t_ofs();
    t_pcrel();
    t_abs();
    t_illegal();
    t_indirect();
    t_wrap();
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule